// File: doc/BRIEF.md
# General-Purpose Event Status Controller

This block keeps the sticky status word of a power-management event group. Hardware sources set status bits: sixteen general-purpose input pins, each with its own input-mode and polarity control; two USB wake requests; and one internal power-management event from the first bus. Software clears a bit by writing 1 to its position. The enable word, the current sleep state and the SCI-select control come in as inputs from neighbouring logic.

From status, enable and sleep state the block produces three outputs. The first is a level wake request for a sleeping system. The other two are one-cycle SCI and SMI pulses, raised while the system is running. The status word has two reset domains. An asynchronous resume-well reset clears the whole word. A synchronous soft platform reset clears only the pin half.

Top module: `acpi_gpe_status`

## Requirements
- R1: While `rst_resume_n` is low, `rd_data` reads 00000000h, and `wake`, `sci_pulse` and `smi_pulse` are 0.
- R2: A write (`wr_en`=1) with 1 in an implemented bit position clears that bit at the next clock edge. A 0 in the write data leaves the bit unchanged. `rd_data` always shows the current status word.
- R3: Status bit 16+k (k=0..15, so bit 31 is pin 15) becomes set at the clock edge after a cycle in which `gpio_is_input[k]`=1 and `gpio_pin[k]` XOR `gpio_inv[k]` = 1. The bit stays set until it is cleared.
- R4: Bit 0 is set by `usb_wake_req[0]` and bit 1 by `usb_wake_req[1]`. Bit 2 is set by `pme_bus0`, except in a cycle where `sleep_state`=5 and `s5_override`=1. In such a cycle `pme_bus0` leaves bit 2 untouched, and a bit 2 that is already set does not drive `wake`.
- R5: If a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R6: When `sleep_state` is not 0 (values 1 to 5 are S1 to S5; 6 and 7 also count as asleep), `wake` is 1 exactly while some bit is set in both status and `enable`, subject to the exception in R4.
- R7: When `sleep_state`=0, `wake` is 0.
- R8: Let the active vector be status AND `enable` while `sleep_state`=0, and 0 otherwise. When any bit of it rises compared with the previous cycle, a single-cycle pulse is issued. If `sci_en`=0 the pulse is `smi_pulse`. If `sci_en`=1 the pulse is `sci_pulse`, except that a pin bit k counts only when `gpio_route[2k+1:2k]` = 2'b10.
- R9: When the system returns to `sleep_state`=0 with an enabled status bit still set, exactly one pulse is issued, in the first cycle of S0, and none after it while that bit stays set.
- R10: A cycle with `soft_rst`=1 clears bits 31:16 at the next edge, and this overrides any set of those bits. Bits 15:0 keep their value and still accept sets.
- R11: Bits 15:3 always read 0. Writes and events never change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_resume_n | input | 1 | Asynchronous resume-well reset, active low, clears all status |
| soft_rst | input | 1 | Synchronous platform reset, clears the pin half |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | 32 | Write-1-to-clear data |
| rd_data | output | 32 | Current status word |
| enable | input | 32 | Matching enable word |
| gpio_pin | input | 16 | Pin levels |
| gpio_is_input | input | 16 | Per-pin input-mode flag |
| gpio_inv | input | 16 | Per-pin polarity inversion |
| gpio_route | input | 32 | Two route bits per pin, 2'b10 selects SCI |
| usb_wake_req | input | 2 | USB controller wake requests |
| pme_bus0 | input | 1 | Bus-0 power-management event |
| sleep_state | input | 3 | 0 = S0, 1..5 = S1..S5 |
| s5_override | input | 1 | S5 was reached by power-button override |
| sci_en | input | 1 | 1 routes events to SCI, 0 to SMI |
| wake | output | 1 | Wake request level |
| sci_pulse | output | 1 | One-cycle SCI pulse |
| smi_pulse | output | 1 | One-cycle SMI pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit word, 16 pins and two USB sources. This places the pin half at bits 31:16, the bus-0 event at bit 2 and the reserved gap at bits 15:3, so the exact bit positions named in the requirements are the ones exercised. With these values, random stimulus reaches overlapping sets and clears in both halves, soft resets with lower-half events pending, and sleep-state changes with enabled status pending. Directed cases add the power-button-override S5 case and the return to S0.

// File: rtl/acpi_gpe_status.sv
module acpi_gpe_status #(
  parameter int W     = 32,
  parameter int NGPIO = 16,
  parameter int NUSB  = 2
) (
  input  logic                 clk,
  input  logic                 rst_resume_n,
  input  logic                 soft_rst,
  input  logic                 wr_en,
  input  logic [W-1:0]         wr_data,
  output logic [W-1:0]         rd_data,
  input  logic [W-1:0]         enable,
  input  logic [NGPIO-1:0]     gpio_pin,
  input  logic [NGPIO-1:0]     gpio_is_input,
  input  logic [NGPIO-1:0]     gpio_inv,
  input  logic [2*NGPIO-1:0]   gpio_route,
  input  logic [NUSB-1:0]      usb_wake_req,
  input  logic                 pme_bus0,
  input  logic [2:0]           sleep_state,
  input  logic                 s5_override,
  input  logic                 sci_en,
  output logic                 wake,
  output logic                 sci_pulse,
  output logic                 smi_pulse
);

  localparam int GL = W - NGPIO;
  localparam int PME = NUSB;
  localparam logic [W-1:0] LOW_MASK = W'((1 << (NUSB + 1)) - 1);
  localparam logic [W-1:0] HI_MASK  = ~((W'(1) << GL) - W'(1));
  localparam logic [W-1:0] IMPL     = HI_MASK | LOW_MASK;
  localparam logic [W-1:0] PME_BIT  = W'(1) << PME;

  logic [W-1:0]     status, set_vec, clr_vec, act, act_q, rise, sci_sel, wake_mask;
  logic [NGPIO-1:0] gpio_hit, gpio_sci_ok;
  logic             in_s0, pme_block;

  assign in_s0     = (sleep_state == 3'd0);
  assign pme_block = (sleep_state == 3'd5) && s5_override;

  for (genvar k = 0; k < NGPIO; k++) begin : g_pin
    assign gpio_hit[k]    = gpio_is_input[k] & (gpio_pin[k] ^ gpio_inv[k]);
    assign gpio_sci_ok[k] = (gpio_route[2*k +: 2] == 2'b10);
  end

  assign set_vec = {gpio_hit, {(GL-NUSB-1){1'b0}}, pme_bus0 & ~pme_block, usb_wake_req};
  assign clr_vec = wr_en ? (wr_data & IMPL) : '0;

  always_ff @(posedge clk or negedge rst_resume_n) begin
    if (!rst_resume_n) begin
      status <= '0;
      act_q  <= '0;
    end else begin
      if (soft_rst)
        status <= ((status & ~clr_vec) | set_vec) & ~HI_MASK;
      else
        status <= (status & ~clr_vec) | set_vec;
      act_q <= act;
    end
  end

  assign rd_data   = status;
  assign wake_mask = pme_block ? ~PME_BIT : '1;
  assign wake      = !in_s0 && |(status & enable & wake_mask);

  assign act       = in_s0 ? (status & enable) : '0;
  assign rise      = act & ~act_q;
  assign sci_sel   = {gpio_sci_ok, {GL{1'b1}}};
  assign sci_pulse = sci_en && |(rise & sci_sel);
  assign smi_pulse = !sci_en && |rise;

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_resume_n)
    wr_en |=> (status & $past(wr_data & ~set_vec)) == '0); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_resume_n)
    !soft_rst |=> ($past(set_vec) & ~status) == '0); // R5
  AST_SOFT_UPPER: assert property (@(posedge clk) disable iff (!rst_resume_n)
    soft_rst |=> (status & HI_MASK) == '0); // R10
  AST_SOFT_LOWER: assert property (@(posedge clk) disable iff (!rst_resume_n)
    soft_rst && !wr_en |=> ($past(status) & LOW_MASK & ~status) == '0); // R10
  AST_PME_BLOCK: assert property (@(posedge clk) disable iff (!rst_resume_n)
    pme_block && !status[PME] |=> !status[PME]); // R4
  AST_NO_WAKE_S0: assert property (@(posedge clk) disable iff (!rst_resume_n)
    in_s0 |-> !wake); // R7
  AST_PULSE_S0: assert property (@(posedge clk) disable iff (!rst_resume_n)
    (sci_pulse || smi_pulse) |-> in_s0); // R8
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_resume_n)
    !(sci_pulse && smi_pulse)); // R8
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_resume_n)
    (rd_data & ~IMPL) == '0); // R11

endmodule

// File: tb/test_acpi_gpe_status.sv
`timescale 1ns/1ps
module test_acpi_gpe_status;
  logic        clk = 0;
  logic        rst_resume_n = 0;
  logic        soft_rst = 0, wr_en = 0, pme_bus0 = 0, s5_override = 0, sci_en = 0;
  logic [31:0] wr_data = 0, enable = 0, gpio_route = 0;
  logic [15:0] gpio_pin = 0, gpio_is_input = 0, gpio_inv = 0;
  logic [1:0]  usb_wake_req = 0;
  logic [2:0]  sleep_state = 0;
  logic [31:0] rd_data;
  logic        wake, sci_pulse, smi_pulse;
  int checks = 0, errors = 0;
  logic [31:0] m_stat = 0, m_actq = 0;

  always #5 clk = ~clk;

  acpi_gpe_status i_acpi_gpe_status (
    .clk(clk), .rst_resume_n(rst_resume_n), .soft_rst(soft_rst), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .enable(enable), .gpio_pin(gpio_pin),
    .gpio_is_input(gpio_is_input), .gpio_inv(gpio_inv), .gpio_route(gpio_route),
    .usb_wake_req(usb_wake_req), .pme_bus0(pme_bus0), .sleep_state(sleep_state),
    .s5_override(s5_override), .sci_en(sci_en), .wake(wake),
    .sci_pulse(sci_pulse), .smi_pulse(smi_pulse));

  task automatic check(input bit ok, input string tag, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  function automatic bit f_block();
    return sleep_state == 3'd5 && s5_override;
  endfunction

  function automatic logic [31:0] f_set();
    logic [31:0] s = 0;
    s[31:16] = gpio_is_input & (gpio_pin ^ gpio_inv);
    s[0] = usb_wake_req[0];
    s[1] = usb_wake_req[1];
    s[2] = pme_bus0 && !f_block();
    return s;
  endfunction

  function automatic logic [31:0] f_act();
    return (sleep_state == 0) ? (m_stat & enable) : 32'h0;
  endfunction

  function automatic bit f_wake();
    logic [31:0] m = f_block() ? 32'hFFFF_FFFB : 32'hFFFF_FFFF;
    return sleep_state != 0 && |(m_stat & enable & m);
  endfunction

  function automatic bit f_sci();
    logic [31:0] r = f_act() & ~m_actq;
    logic [31:0] ok = 32'h0000_FFFF;
    for (int k = 0; k < 16; k++) ok[16+k] = (gpio_route[2*k +: 2] == 2'b10);
    return sci_en && |(r & ok);
  endfunction

  function automatic bit f_smi();
    return !sci_en && |(f_act() & ~m_actq);
  endfunction

  task automatic step();
    logic [31:0] nxt, clr;
    #1;
    check(rd_data === m_stat, "R2 R3 R4 R5 R11 status", rd_data, m_stat);
    check(wake === f_wake(), (sleep_state == 0) ? "R7 wake" : "R6 wake", {31'b0, wake}, {31'b0, f_wake()});
    check(sci_pulse === f_sci(), "R8 sci", {31'b0, sci_pulse}, {31'b0, f_sci()});
    check(smi_pulse === f_smi(), "R8 smi", {31'b0, smi_pulse}, {31'b0, f_smi()});
    clr = wr_en ? (wr_data & 32'hFFFF_0007) : 32'h0;
    nxt = (m_stat & ~clr) | f_set();
    if (soft_rst) nxt[31:16] = 16'h0;
    @(posedge clk);
    m_actq = f_act();
    m_stat = nxt;
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; soft_rst = 0; usb_wake_req = 0; pme_bus0 = 0; gpio_is_input = 0;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    gpio_is_input = 16'hFFFF; gpio_pin = 16'hFFFF; usb_wake_req = 2'b11; pme_bus0 = 1;
    enable = '1; sleep_state = 3;
    repeat (3) @(negedge clk);
    check(rd_data === 32'h0, "R1 reset status", rd_data, 32'h0);
    check({wake, sci_pulse, smi_pulse} === 3'b0, "R1 reset outputs", {29'b0, wake, sci_pulse, smi_pulse}, 32'h0);
    idle(); sleep_state = 0; enable = 0;
    @(negedge clk); rst_resume_n = 1; @(negedge clk);

    // R3: pin 15 active-low with inversion, pin 0 active-high
    gpio_is_input = 16'h8001; gpio_inv = 16'h8000; gpio_pin = 16'h0001; step(); idle();
    check(rd_data[31] && rd_data[16], "R3 pin mapping", rd_data, 32'h8001_0000);
    // R5: set and clear on same bit
    gpio_is_input = 16'h0001; gpio_inv = 0; gpio_pin = 16'h0001; wr_en = 1; wr_data = 32'h0001_0000; step(); idle();
    check(rd_data[16] === 1'b1, "R5 set wins", rd_data, 32'h8001_0000);
    // R2: write 1 clears, write 0 keeps
    wr_en = 1; wr_data = 32'h0001_0000; step(); idle();
    check(rd_data === 32'h8000_0000, "R2 w1c", rd_data, 32'h8000_0000);
    // R11: reserved bits ignore writes
    wr_en = 1; wr_data = 32'h0000_FFF8; step(); idle();
    check(rd_data[15:3] === 13'h0, "R11 reserved", rd_data, 32'h8000_0000);
    // R10: soft reset keeps lower half
    usb_wake_req = 2'b01; step(); idle(); soft_rst = 1; step(); idle();
    check(rd_data === 32'h0000_0001, "R10 soft reset", rd_data, 32'h1);
    // R4: power-button-override S5 blocks bus-0 event
    sleep_state = 5; s5_override = 1; enable = 32'h4; pme_bus0 = 1; step(); idle();
    check(rd_data[2] === 1'b0, "R4 pme blocked", rd_data, 32'h1);
    s5_override = 0; pme_bus0 = 1; step(); idle(); step();
    check(wake === 1'b1, "R6 pme wake from normal S5", {31'b0, wake}, 32'h1);
    // R9: return to S0 gives one SCI pulse
    sci_en = 1; sleep_state = 0; #1;
    check(sci_pulse === 1'b1, "R9 pulse on S0 entry", {31'b0, sci_pulse}, 32'h1);
    step(); #1;
    check(sci_pulse === 1'b0, "R9 single pulse", {31'b0, sci_pulse}, 32'h0);
    // R8: pin routing not SCI suppresses pulse
    enable = 32'h0002_0000; gpio_route = 32'h0000_0004; gpio_is_input = 16'h0002; gpio_pin = 16'h0002;
    step(); idle(); #1;
    check(sci_pulse === 1'b0, "R8 route suppress", {31'b0, sci_pulse}, 32'h0);
    @(negedge clk);
    m_actq = f_act();

    for (int i = 0; i < 3000; i++) begin
      wr_en = ($urandom % 4) == 0;
      wr_data = $urandom;
      soft_rst = ($urandom % 24) == 0;
      enable = $urandom;
      gpio_pin = 16'($urandom);
      gpio_is_input = 16'($urandom & $urandom & $urandom);
      gpio_inv = 16'($urandom);
      gpio_route = $urandom;
      usb_wake_req = 2'(($urandom % 6 == 0) ? $urandom : 0);
      pme_bus0 = ($urandom % 6) == 0;
      sleep_state = ($urandom % 2) ? 3'd0 : 3'($urandom);
      s5_override = 1'($urandom);
      sci_en = 1'($urandom);
      step();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule